// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block watches a bank of general-purpose input pins and turns qualifying activity on them into one level-sensitive, active-high interrupt for a processor core. Each pin has its own interrupt configuration word and its own sticky status bit. Both sit in a small memory-mapped register window, written through a single-cycle write strobe and read combinationally by address.

Every pin input first passes through a two-stage synchronizer. The synchronized sample is then tested against the pin's detect mode: level, edge towards the active level, edge away from it, or any change. A raw-status gate decides whether a detected event is latched into the status bit. Software clears the status by writing zero. The interrupt output is the registered OR over all pins that are enabled, have status set, and are routed to the core id fixed at build time.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads 0x0E0 (target field 7, all other bits 0), every status register reads 0, and irq_o is 0.
- R2: Pin k owns a 16-byte group at byte address 0x1000 + 0x10*k. Offset +0x8 is the configuration word: bit 0 enable, bit 1 polarity (1 = active high), bits [3:2] detect mode, bit 4 raw-status gate, bits [7:5] target id, bit 8 a stored direct-route flag with no effect. Offset +0xC holds status in bit 0. Offsets +0x0 and +0x4, and addresses outside the bank, read 0 and ignore writes.
- R3: In detect mode 0 (level), status is set on every cycle in which the synchronized input equals the polarity bit. A clear written while that level persists is overridden, so status stays 1.
- R4: Detect mode 1 latches on a transition into the active level (rising when polarity is 1, falling when it is 0). Detect mode 2 latches on a transition out of it (falling when polarity is 1, rising when it is 0).
- R5: Detect mode 3 latches on every transition of the synchronized input, whatever the polarity bit.
- R6: In an edge mode, a set status bit holds until the status register is written with bit 0 = 0. A write with bit 0 = 1 leaves it unchanged.
- R7: While the raw-status gate (bit 4) is 0, no event sets status.
- R8: The enable bit does not gate latching. Status can be set and cleared while enable is 0, and setting enable afterwards raises no interrupt.
- R9: irq_o is 1 exactly one cycle after some pin has enable = 1, status = 1 and target id equal to CORE_ID (default 4). A target of 7, or any other id, keeps that pin out of irq_o.
- R10: A pin change driven before clock edge E1 reaches status at E3 and irq_o at E4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte address for read and write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| irq_o | output | 1 | Summary interrupt, active high |

## Verification
Detection is tried with a held high level and a held low level. These show whether the level mode follows the polarity bit and re-latches after a clear. Single rising and falling steps are then applied under each edge mode and both polarity settings. Each edge mode has to fire on exactly one direction, and the both-edges mode has to fire on either. The same rising step is repeated with the raw gate off, with enable off, and with the target id set to 7, to another id and to the matching id. This separates a latching fault from a routing fault. A timed step on one pin fixes the number of synchronizer and register stages between pin and interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned CFG_W    = 9;
  localparam int unsigned GRP_LG   = 4;      // 16-byte group per pin
  localparam logic [1:0]  SUB_CFG  = 2'd2;   // word +0x8
  localparam logic [1:0]  SUB_STS  = 2'd3;   // word +0xC
  localparam logic [2:0]  TGT_NONE = 3'd7;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_TO    = 2'd1,
    DET_FROM  = 2'd2,
    DET_ANY   = 2'd3
  } det_mode_e;

  typedef struct packed {
    logic       dc_en;
    logic [2:0] tgt;
    logic       raw_en;
    det_mode_e  mode;
    logic       pol;
    logic       en;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RST = '{dc_en: 1'b0, tgt: TGT_NONE, raw_en: 1'b0,
                                   mode: DET_LEVEL, pol: 1'b0, en: 1'b0};
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter logic [2:0] CORE_ID = 3'd4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cfg_we_i,
  input  irq_cfg_t cfg_wdata_i,
  input  logic     sts_clr_i,
  input  logic     smp_i,
  output irq_cfg_t cfg_o,
  output logic     sts_o,
  output logic     hit_o
);
  irq_cfg_t cfg_q;
  logic     prev_q, sts_q;
  logic     act, act_prev, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= smp_i;
  end

  // fold polarity in so both samples are viewed active-high
  assign act      = smp_i  ~^ cfg_q.pol;
  assign act_prev = prev_q ~^ cfg_q.pol;

  always_comb begin
    unique case (cfg_q.mode)
      DET_LEVEL: evt = act;
      DET_TO:    evt = act & ~act_prev;
      DET_FROM:  evt = ~act & act_prev;
      DET_ANY:   evt = smp_i ^ prev_q;
      default:   evt = 1'b0;
    endcase
  end

  // a live event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else if (cfg_q.raw_en && evt) sts_q <= 1'b1;
    else if (sts_clr_i) sts_q <= 1'b0;
  end

  assign cfg_o = cfg_q;
  assign sts_o = sts_q;
  assign hit_o = cfg_q.en & sts_q & (cfg_q.tgt == CORE_ID);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 32'h1000,
  parameter logic [2:0]  CORE_ID   = 3'd4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                irq_o
);
  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int unsigned SPAN  = NUM_PINS << GRP_LG;

  logic [ADDR_W-1:0]   off;
  logic                in_rng, aligned;
  logic [PIN_W-1:0]    sel;
  logic [1:0]          sub;
  logic [NUM_PINS-1:0] smp_q, sts_q, hit, sts_clr, cfg_we;
  irq_cfg_t            cfg_q [NUM_PINS];
  irq_cfg_t            wcfg;
  logic                unused_bits;

  assign off     = bus_addr_i - ADDR_W'(BASE_ADDR);
  assign in_rng  = (32'(bus_addr_i) >= BASE_ADDR) && (32'(off) < SPAN);
  assign aligned = (off[1:0] == 2'b00);
  assign sel     = off[GRP_LG +: PIN_W];
  assign sub     = off[3:2];
  assign wcfg    = irq_cfg_t'(bus_wdata_i[CFG_W-1:0]);
  assign unused_bits = ^{off, bus_wdata_i};

  gpio_irq_sync #(.W(NUM_PINS)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (smp_q)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic hit_grp;
    assign hit_grp    = bus_we_i & in_rng & aligned & (32'(sel) == k);
    assign cfg_we[k]  = hit_grp & (sub == SUB_CFG);
    assign sts_clr[k] = hit_grp & (sub == SUB_STS) & ~bus_wdata_i[0];

    gpio_irq_pin #(.CORE_ID(CORE_ID)) pin_i_u (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we[k]),
      .cfg_wdata_i(wcfg),
      .sts_clr_i  (sts_clr[k]),
      .smp_i      (smp_q[k]),
      .cfg_o      (cfg_q[k]),
      .sts_o      (sts_q[k]),
      .hit_o      (hit[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (in_rng && aligned) begin
      for (int k = 0; k < NUM_PINS; k++) begin
        if (32'(sel) == k) begin
          if (sub == SUB_CFG)      bus_rdata_o[CFG_W-1:0] = cfg_q[k];
          else if (sub == SUB_STS) bus_rdata_o[0]         = sts_q[k];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else irq_o <= |hit;
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter logic [2:0]  CORE_ID  = 3'd4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                irq_i,
  input irq_cfg_t            cfg_i [NUM_PINS],
  input logic [NUM_PINS-1:0] sts_i,
  input logic [NUM_PINS-1:0] smp_i,
  input logic [NUM_PINS-1:0] clr_i
);
  logic [NUM_PINS-1:0] raw_v, lvl_v, edge_v, route_v;

  always_comb begin
    for (int k = 0; k < NUM_PINS; k++) begin
      raw_v[k]   = cfg_i[k].raw_en;
      lvl_v[k]   = cfg_i[k].raw_en && (cfg_i[k].mode == DET_LEVEL) && (smp_i[k] == cfg_i[k].pol);
      edge_v[k]  = (cfg_i[k].mode != DET_LEVEL);
      route_v[k] = cfg_i[k].en && (cfg_i[k].tgt == CORE_ID);
    end
  end

  p_raw_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_i & ~$past(sts_i) & ~$past(raw_v)) == '0));

  p_level_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~sts_i & $past(lvl_v)) == '0));

  p_edge_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~sts_i & $past(sts_i & edge_v & ~clr_i)) == '0));

  p_irq_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == $past(|(sts_i & route_v))));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .CORE_ID(CORE_ID)) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .irq_i (irq_o),
  .cfg_i (cfg_q),
  .sts_i (sts_q),
  .smp_i (smp_q),
  .clr_i (sts_clr)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pins = '0;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins), .irq_o(irq)
  );

  function automatic logic [15:0] a_cfg(int k); return 16'(32'h1008 + 16 * k); endfunction
  function automatic logic [15:0] a_sts(int k); return 16'(32'h100C + 16 * k); endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_pin(int k, logic v);
    @(negedge clk); pins[k] = v;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic park(int k);
    wr(a_cfg(k), 32'h0E0);
    wr(a_sts(k), 32'h0);
    settle(3);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(a_cfg(0), d); check("R1 cfg0", d, 32'h0E0);
    rd(a_cfg(7), d); check("R1 cfg7", d, 32'h0E0);
    rd(a_sts(3), d); check("R1 sts3", d, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(a_cfg(3), 32'hFFFF_FFFF);
    rd(a_cfg(3), d); check("R2 cfg rw", d, 32'h1FF);
    wr(16'h1030, 32'hFFFF_FFFF);
    rd(16'h1030, d); check("R2 off0", d, 32'h0);
    rd(16'h1034, d); check("R2 off4", d, 32'h0);
    wr(16'h1088, 32'h1FF);
    rd(16'h1088, d); check("R2 range", d, 32'h0);
    rd(a_cfg(0), d); check("R2 neighbour", d, 32'h0E0);
    park(3);
    rd(a_sts(3), d); check("R2 sts parked", d, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(a_cfg(1), 32'h093);
    settle(3);
    rd(a_sts(1), d); check("R3 low idle", d, 32'h0);
    set_pin(1, 1'b1); settle(5);
    rd(a_sts(1), d); check("R3 high latch", d, 32'h1);
    check("R3 irq", 32'(irq), 32'h1);
    wr(a_sts(1), 32'h0); settle(2);
    rd(a_sts(1), d); check("R3 reassert", d, 32'h1);
    set_pin(1, 1'b0); settle(4);
    wr(a_sts(1), 32'h0); settle(3);
    rd(a_sts(1), d); check("R3 cleared", d, 32'h0);
    check("R3 irq off", 32'(irq), 32'h0);
    wr(a_cfg(1), 32'h091); settle(3);
    rd(a_sts(1), d); check("R3 pol0 low", d, 32'h1);
    park(1);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(a_cfg(2), 32'h097); settle(2);
    set_pin(2, 1'b1); settle(5);
    rd(a_sts(2), d); check("R4 to pol1 rise", d, 32'h1);
    wr(a_sts(2), 32'h0);
    set_pin(2, 1'b0); settle(5);
    rd(a_sts(2), d); check("R4 to pol1 fall", d, 32'h0);
    wr(a_cfg(2), 32'h095); settle(2);
    set_pin(2, 1'b1); settle(5);
    rd(a_sts(2), d); check("R4 to pol0 rise", d, 32'h0);
    set_pin(2, 1'b0); settle(5);
    rd(a_sts(2), d); check("R4 to pol0 fall", d, 32'h1);
    wr(a_sts(2), 32'h0);
    wr(a_cfg(2), 32'h09B); settle(2);
    set_pin(2, 1'b1); settle(5);
    rd(a_sts(2), d); check("R4 from pol1 rise", d, 32'h0);
    set_pin(2, 1'b0); settle(5);
    rd(a_sts(2), d); check("R4 from pol1 fall", d, 32'h1);
    park(2);
  endtask

  task automatic t_both;
    logic [31:0] d;
    wr(a_cfg(4), 32'h09D); settle(2);
    set_pin(4, 1'b1); settle(5);
    rd(a_sts(4), d); check("R5 rise", d, 32'h1);
    wr(a_sts(4), 32'h0); settle(2);
    rd(a_sts(4), d); check("R5 clear", d, 32'h0);
    set_pin(4, 1'b0); settle(5);
    rd(a_sts(4), d); check("R5 fall", d, 32'h1);
    settle(10);
    rd(a_sts(4), d); check("R6 sticky", d, 32'h1);
    wr(a_sts(4), 32'h1); settle(2);
    rd(a_sts(4), d); check("R6 write one", d, 32'h1);
    wr(a_sts(4), 32'h0); settle(2);
    rd(a_sts(4), d); check("R6 write zero", d, 32'h0);
    park(4);
  endtask

  task automatic t_raw;
    logic [31:0] d;
    wr(a_cfg(5), 32'h087); settle(2);
    set_pin(5, 1'b1); settle(5);
    rd(a_sts(5), d); check("R7 gated sts", d, 32'h0);
    check("R7 gated irq", 32'(irq), 32'h0);
    set_pin(5, 1'b0); settle(3);
    park(5);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(a_cfg(0), 32'h096); settle(2);
    set_pin(0, 1'b1); settle(5);
    rd(a_sts(0), d); check("R8 latch disabled", d, 32'h1);
    check("R8 no irq", 32'(irq), 32'h0);
    wr(a_sts(0), 32'h0);
    wr(a_cfg(0), 32'h097); settle(3);
    check("R8 irq after enable", 32'(irq), 32'h0);
    set_pin(0, 1'b0); settle(3);
    park(0);
  endtask

  task automatic t_target;
    logic [31:0] d;
    wr(a_cfg(6), 32'h0F7); settle(2);
    set_pin(6, 1'b1); settle(5);
    rd(a_sts(6), d); check("R9 tgt7 sts", d, 32'h1);
    check("R9 tgt7 irq", 32'(irq), 32'h0);
    wr(a_cfg(6), 32'h077); settle(3);
    check("R9 tgt3 irq", 32'(irq), 32'h0);
    wr(a_cfg(6), 32'h097); settle(3);
    check("R9 tgt4 irq", 32'(irq), 32'h1);
    set_pin(6, 1'b0);
    park(6);
    check("R9 irq drop", 32'(irq), 32'h0);
  endtask

  task automatic t_latency;
    wr(a_cfg(7), 32'h097); settle(3);
    set_pin(7, 1'b1);
    repeat (3) @(posedge clk);
    #1 check("R10 irq at E3", 32'(irq), 32'h0);
    @(posedge clk);
    #1 check("R10 irq at E4", 32'(irq), 32'h1);
    set_pin(7, 1'b0);
    park(7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle(2);
    t_reset();
    t_map();
    t_level();
    t_edge();
    t_both();
    t_raw();
    t_enable();
    t_target();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule